// File: doc/BRIEF.md
# Dual-Channel Doorbell Mailbox

The doorbell mailbox lets an application processor and a system control processor signal each other through shared status words. There are two channels, a low-priority one (index 0) and a high-priority one (index 1), in each direction. A sender writes a nonzero pattern into the set register of a channel. The receiver sees an interrupt for as long as that status word is nonzero. It reads the message from a shared payload window and acknowledges by writing all ones to the clear register. The sender treats the transfer as finished once the status word reads back as zero.

Each side has its own simple register bus slave. Both slaves see the same 12-bit byte address map. Registers sit in the lower half of the map and the payload RAM sits in the upper half, starting at 0x800. Reads return data one cycle after the request, together with a one-cycle valid pulse. The payload memory is one RAM per direction, written by the sending side only and readable from both sides.

Top module: `dbell_mailbox`

## Requirements
- R1: A synchronous reset clears all four status words and drives both interrupt vectors low. After reset, every status offset reads zero.
- R2: Register map. The receive bank (controller to application) starts at 0x000 and the transmit bank (application to controller) starts at 0x100. Channel c of a bank sits at c×0x20, with status at +0x0, set at +0x8 and clear at +0x10. Channel 0 is low priority and channel 1 is high priority.
- R3: A write to a set register ORs the written value into that status word, effective at the clock edge that accepts the write.
- R4: A write to a clear register removes the written one-bits from that status word. Writing 0xFFFFFFFF returns it to zero.
- R5: When sets and clears hit one status word in the same cycle, from either side or both, any bit written as one by a set ends up as one.
- R6: app_irq[c] is high exactly while the receive status word of channel c is nonzero. It changes at the same edge as the status word.
- R7: ctl_irq[c] is high exactly while the transmit status word of channel c is nonzero. It changes at the same edge as the status word.
- R8: Reads of set, clear, reserved or unmapped register offsets return zero. Writes to unmapped register offsets change no status word.
- R9: Both bus sides address the same status words. A pattern set from one side is read back unchanged from the other side.
- R10: Payload map. The receive window of channel c starts at 0x800 + c×0x400 and the transmit window starts 0x200 above it. Each window holds 128 32-bit words, and both sides read the same contents.
- R11: Only the controller side writes the receive windows and only the application side writes the transmit windows. Payload writes from the other side are ignored.
- R12: A read request accepted at one edge presents its data and a one-cycle rvalid pulse after that edge. A write request produces no rvalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_req | input | 1 | Application-side request strobe |
| app_we | input | 1 | Application-side write enable |
| app_addr | input | 12 | Application-side byte address |
| app_wdata | input | 32 | Application-side write data |
| app_rdata | output | 32 | Application-side read data |
| app_rvalid | output | 1 | Application-side read data valid |
| ctl_req | input | 1 | Controller-side request strobe |
| ctl_we | input | 1 | Controller-side write enable |
| ctl_addr | input | 12 | Controller-side byte address |
| ctl_wdata | input | 32 | Controller-side write data |
| ctl_rdata | output | 32 | Controller-side read data |
| ctl_rvalid | output | 1 | Controller-side read data valid |
| app_irq | output | 2 | Receive interrupts toward the application, one per channel |
| ctl_irq | output | 2 | Interrupts toward the controller, one per channel |

## Verification
On every cycle the assertions check several properties. Each interrupt line must match the nonzero state of its status word. Set bits must survive a simultaneous clear. Status words must hold still in any cycle without a write. Each read must draw exactly one rvalid. The directed scenarios cover what only observed data can show. They confirm that the address map is decoded exactly, with neighbouring and reserved offsets reading zero and ignoring writes. They confirm that both sides see one set of status words, and that payload ownership per direction rejects writes from the wrong side.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // two channels (0 = low priority, 1 = high priority) in each direction
  localparam int N_CH   = 2;
  localparam int N_DIR  = 2;
  localparam int N_WORD = N_CH * N_DIR;  // {bank, channel}: 0 rx lo, 1 rx hi, 2 tx lo, 3 tx hi
  localparam int N_SIDE = 2;             // 0 application, 1 controller

  typedef enum logic [1:0] {
    KIND_STAT = 2'd0,
    KIND_SET  = 2'd1,
    KIND_CLR  = 2'd2,
    KIND_RSV  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/mbx_bus_decode.sv
module mbx_bus_decode
  import mbx_pkg::*;
#(
  parameter int DW      = 32,
  parameter int WIN_AW  = 7,
  parameter int OWN_DIR = 0,
  localparam int AW     = WIN_AW + 5
) (
  input  logic                       req,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [N_WORD-1:0][DW-1:0]  set_mask,
  output logic [N_WORD-1:0][DW-1:0]  clr_mask,
  output logic                       rd_req,
  output logic                       rd_stat,
  output logic [1:0]                 rd_word,
  output logic                       rd_pay,
  output logic                       rd_dir,
  output logic                       pay_we,
  output logic [WIN_AW:0]            pay_idx
);
  localparam int PAY_BIT = AW - 1;
  localparam int CH_BIT  = AW - 2;
  localparam int DIR_BIT = AW - 3;
  // register offsets may only use the bank bit, channel bit and kind field
  localparam logic [AW-1:0] REG_USED = AW'(32'h138);

  logic      is_pay;
  logic      reg_ok;
  reg_kind_e kind;
  logic [1:0] word;

  assign is_pay = addr[PAY_BIT];
  assign kind   = reg_kind_e'(addr[4:3]);
  assign word   = {addr[8], addr[5]};
  assign reg_ok = !is_pay && ((addr & ~REG_USED) == '0);

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (req && we && reg_ok) begin
      case (kind)
        KIND_SET: set_mask[word] = wdata;
        KIND_CLR: clr_mask[word] = wdata;
        default: ;
      endcase
    end
  end

  assign rd_req  = req && !we;
  assign rd_stat = rd_req && reg_ok && (kind == KIND_STAT);
  assign rd_word = word;
  assign rd_pay  = rd_req && is_pay;
  assign rd_dir  = addr[DIR_BIT];
  assign pay_we  = req && we && is_pay && (addr[DIR_BIT] == OWN_DIR[0]);
  assign pay_idx = {addr[CH_BIT], addr[DIR_BIT-1:2]};
endmodule

// File: rtl/mbx_stat_word.sv
module mbx_stat_word #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_a,
  input  logic [DW-1:0] clr_a,
  input  logic [DW-1:0] set_b,
  input  logic [DW-1:0] clr_b,
  output logic [DW-1:0] q,
  output logic          nz
);
  logic [DW-1:0] nxt;

  // set is applied after clear so it wins on overlapping bits
  assign nxt = (q & ~(clr_a | clr_b)) | set_a | set_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      nz <= 1'b0;
    end else begin
      q  <= nxt;
      nz <= (nxt != '0);
    end
  end
endmodule

// File: rtl/mbx_pay_ram.sv
module mbx_pay_ram #(
  parameter int DW = 32,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WIN_WORDS = 128,
  localparam int WIN_AW   = $clog2(WIN_WORDS),
  localparam int ADDR_W   = WIN_AW + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              app_req,
  input  logic              app_we,
  input  logic [ADDR_W-1:0] app_addr,
  input  logic [DATA_W-1:0] app_wdata,
  output logic [DATA_W-1:0] app_rdata,
  output logic              app_rvalid,
  input  logic              ctl_req,
  input  logic              ctl_we,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              ctl_rvalid,
  output logic [N_CH-1:0]   app_irq,
  output logic [N_CH-1:0]   ctl_irq
);
  localparam int PAW = WIN_AW + 1;

  logic                          req_s   [N_SIDE];
  logic                          we_s    [N_SIDE];
  logic [ADDR_W-1:0]             addr_s  [N_SIDE];
  logic [DATA_W-1:0]             wdata_s [N_SIDE];
  logic [DATA_W-1:0]             rdata_s [N_SIDE];
  logic                          rvld_s  [N_SIDE];
  logic [N_WORD-1:0][DATA_W-1:0] set_m   [N_SIDE];
  logic [N_WORD-1:0][DATA_W-1:0] clr_m   [N_SIDE];
  logic                          rd_req  [N_SIDE];
  logic                          rd_stat [N_SIDE];
  logic [1:0]                    rd_word [N_SIDE];
  logic                          rd_pay  [N_SIDE];
  logic                          rd_dir  [N_SIDE];
  logic                          pay_we  [N_SIDE];
  logic [PAW-1:0]                pay_idx [N_SIDE];
  logic [DATA_W-1:0]             ram_rd  [N_DIR][N_SIDE];

  logic [N_WORD-1:0][DATA_W-1:0] status_q;
  logic [N_WORD-1:0]             nz;

  assign req_s[0]   = app_req;
  assign we_s[0]    = app_we;
  assign addr_s[0]  = app_addr;
  assign wdata_s[0] = app_wdata;
  assign req_s[1]   = ctl_req;
  assign we_s[1]    = ctl_we;
  assign addr_s[1]  = ctl_addr;
  assign wdata_s[1] = ctl_wdata;

  // per side: decode and registered read path
  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    logic              stat_q;
    logic              pay_q;
    logic              dir_q;
    logic [DATA_W-1:0] sdata_q;

    mbx_bus_decode #(
      .DW      (DATA_W),
      .WIN_AW  (WIN_AW),
      .OWN_DIR ((s == 0) ? 1 : 0)
    ) u_dec (
      .req      (req_s[s]),
      .we       (we_s[s]),
      .addr     (addr_s[s]),
      .wdata    (wdata_s[s]),
      .set_mask (set_m[s]),
      .clr_mask (clr_m[s]),
      .rd_req   (rd_req[s]),
      .rd_stat  (rd_stat[s]),
      .rd_word  (rd_word[s]),
      .rd_pay   (rd_pay[s]),
      .rd_dir   (rd_dir[s]),
      .pay_we   (pay_we[s]),
      .pay_idx  (pay_idx[s])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q  <= 1'b0;
        pay_q   <= 1'b0;
        dir_q   <= 1'b0;
        sdata_q <= '0;
      end else begin
        stat_q  <= rd_req[s];
        pay_q   <= rd_pay[s];
        dir_q   <= rd_dir[s];
        sdata_q <= rd_stat[s] ? status_q[rd_word[s]] : '0;
      end
    end

    assign rvld_s[s]  = stat_q;
    assign rdata_s[s] = pay_q ? ram_rd[dir_q][s] : sdata_q;
  end

  // status words, shared by both sides
  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    mbx_stat_word #(.DW(DATA_W)) u_word (
      .clk   (clk),
      .rst   (rst),
      .set_a (set_m[0][w]),
      .clr_a (clr_m[0][w]),
      .set_b (set_m[1][w]),
      .clr_b (clr_m[1][w]),
      .q     (status_q[w]),
      .nz    (nz[w])
    );
  end

  // payload: one RAM per direction, written only by the sending side
  for (genvar d = 0; d < N_DIR; d++) begin : g_pay
    localparam int OWNER = (d == 1) ? 0 : 1;
    mbx_pay_ram #(.DW(DATA_W), .AW(PAW)) u_ram (
      .clk     (clk),
      .we      (pay_we[OWNER]),
      .waddr   (pay_idx[OWNER]),
      .wdata   (wdata_s[OWNER]),
      .raddr_a (pay_idx[0]),
      .rdata_a (ram_rd[d][0]),
      .raddr_b (pay_idx[1]),
      .rdata_b (ram_rd[d][1])
    );
  end

  assign app_rdata  = rdata_s[0];
  assign app_rvalid = rvld_s[0];
  assign ctl_rdata  = rdata_s[1];
  assign ctl_rvalid = rvld_s[1];
  assign app_irq    = nz[N_CH-1:0];
  assign ctl_irq    = nz[N_WORD-1:N_CH];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               app_req,
  input logic               app_we,
  input logic [AW-1:0]      app_addr,
  input logic [DW-1:0]      app_wdata,
  input logic               app_rvalid,
  input logic               ctl_req,
  input logic               ctl_we,
  input logic [AW-1:0]      ctl_addr,
  input logic [DW-1:0]      ctl_wdata,
  input logic [1:0]         app_irq,
  input logic [1:0]         ctl_irq,
  input logic [3:0][DW-1:0] status
);
  localparam logic [AW-1:0] A_SET_RX_LO = AW'(32'h008);
  localparam logic [AW-1:0] A_CLR_RX_LO = AW'(32'h010);
  localparam logic [AW-1:0] A_SET_TX_HI = AW'(32'h128);
  localparam logic [AW-1:0] A_CLR_TX_HI = AW'(32'h130);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (status == '0 && app_irq == 2'b00 && ctl_irq == 2'b00));

  p_set_sticks_r3: assert property (@(posedge clk) disable iff (rst)
    (app_req && app_we && app_addr == A_SET_RX_LO)
    |=> ((status[0] & $past(app_wdata)) == $past(app_wdata)));

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
    (app_req && app_we && app_addr == A_CLR_RX_LO &&
     !(ctl_req && ctl_we && ctl_addr == A_SET_RX_LO))
    |=> ((status[0] & $past(app_wdata)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (app_req && app_we && app_addr == A_SET_TX_HI &&
     ctl_req && ctl_we && ctl_addr == A_CLR_TX_HI)
    |=> ((status[3] & $past(app_wdata)) == $past(app_wdata)));

  p_app_irq_r6: assert property (@(posedge clk) disable iff (rst)
    app_irq == {(status[1] != '0), (status[0] != '0)});

  p_ctl_irq_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_irq == {(status[3] != '0), (status[2] != '0)});

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!(app_req && app_we) && !(ctl_req && ctl_we)) |=> $stable(status));

  p_rvalid_on_read_r12: assert property (@(posedge clk) disable iff (rst)
    (app_req && !app_we) |=> app_rvalid);

  p_rvalid_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !(app_req && !app_we) |=> !app_rvalid);
endmodule

bind dbell_mailbox mbx_checker #(.DW(DATA_W), .AW(ADDR_W)) u_mbx_checker (
  .clk        (clk),
  .rst        (rst),
  .app_req    (app_req),
  .app_we     (app_we),
  .app_addr   (app_addr),
  .app_wdata  (app_wdata),
  .app_rvalid (app_rvalid),
  .ctl_req    (ctl_req),
  .ctl_we     (ctl_we),
  .ctl_addr   (ctl_addr),
  .ctl_wdata  (ctl_wdata),
  .app_irq    (app_irq),
  .ctl_irq    (ctl_irq),
  .status     (status_q)
);

// File: tb/dbell_mailbox_bench.sv
`timescale 1ns/1ps
module dbell_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        app_req = 1'b0, app_we = 1'b0;
  logic [11:0] app_addr = '0;
  logic [31:0] app_wdata = '0;
  logic [31:0] app_rdata;
  logic        app_rvalid;
  logic        ctl_req = 1'b0, ctl_we = 1'b0;
  logic [11:0] ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        ctl_rvalid;
  logic [1:0]  app_irq, ctl_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbell_mailbox u_dbell_mailbox (
    .clk(clk), .rst(rst),
    .app_req(app_req), .app_we(app_we), .app_addr(app_addr), .app_wdata(app_wdata),
    .app_rdata(app_rdata), .app_rvalid(app_rvalid),
    .ctl_req(ctl_req), .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ctl_rvalid(ctl_rvalid),
    .app_irq(app_irq), .ctl_irq(ctl_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // side 0 = application, side 1 = controller
  task automatic wr(input int side, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    if (side == 0) begin app_req = 1; app_we = 1; app_addr = a; app_wdata = d; end
    else           begin ctl_req = 1; ctl_we = 1; ctl_addr = a; ctl_wdata = d; end
    @(negedge clk);
    app_req = 0; app_we = 0; ctl_req = 0; ctl_we = 0;
  endtask

  task automatic rd(input int side, input logic [11:0] a, output logic [31:0] d,
                    output logic v);
    @(negedge clk);
    if (side == 0) begin app_req = 1; app_we = 0; app_addr = a; end
    else           begin ctl_req = 1; ctl_we = 0; ctl_addr = a; end
    @(negedge clk);
    app_req = 0; ctl_req = 0;
    d = (side == 0) ? app_rdata : ctl_rdata;
    v = (side == 0) ? app_rvalid : ctl_rvalid;
  endtask

  task automatic rchk(input string tag, input int side, input logic [11:0] a,
                      input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    rd(side, a, d, v);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    logic v;
    chk("R1 app_irq", {30'd0, app_irq}, 32'd0);
    chk("R1 ctl_irq", {30'd0, ctl_irq}, 32'd0);
    chk("R12 rvalid idle", {31'd0, app_rvalid}, 32'd0);
    rchk("R1 rx lo", 0, 12'h000, 32'h0);
    rchk("R1 rx hi", 0, 12'h020, 32'h0);
    rchk("R1 tx lo", 1, 12'h100, 32'h0);
    rd(1, 12'h120, d, v);
    chk("R1 tx hi", d, 32'h0);
    chk("R12 rvalid after read", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R12 rvalid one cycle", {31'd0, ctl_rvalid}, 32'd0);
  endtask

  task automatic t_rx_low;
    wr(1, 12'h008, 32'h0000_00F0);
    chk("R6 irq after set", {30'd0, app_irq}, 32'd1);
    rchk("R9 app sees ctl set", 0, 12'h000, 32'h0000_00F0);
    wr(1, 12'h008, 32'h0F00_0001);
    rchk("R3 set ORs", 0, 12'h000, 32'h0F00_00F1);
    wr(0, 12'h010, 32'h0000_00F0);
    rchk("R4 partial clear", 1, 12'h000, 32'h0F00_0001);
    chk("R6 irq held", {30'd0, app_irq}, 32'd1);
    wr(0, 12'h010, 32'hFFFF_FFFF);
    rchk("R4 full clear", 1, 12'h000, 32'h0);
    chk("R6 irq dropped", {30'd0, app_irq}, 32'd0);
  endtask

  task automatic t_rx_high;
    wr(1, 12'h028, 32'h0000_0005);
    chk("R6 high irq", {30'd0, app_irq}, 32'd2);
    rchk("R2 high status", 0, 12'h020, 32'h5);
    rchk("R2 low untouched", 0, 12'h000, 32'h0);
    chk("R7 ctl quiet", {30'd0, ctl_irq}, 32'd0);
    wr(0, 12'h030, 32'hFFFF_FFFF);
    chk("R6 high irq cleared", {30'd0, app_irq}, 32'd0);
  endtask

  task automatic t_tx;
    wr(0, 12'h108, 32'h0000_0001);
    chk("R7 tx lo irq", {30'd0, ctl_irq}, 32'd1);
    chk("R6 app quiet", {30'd0, app_irq}, 32'd0);
    rchk("R2 tx lo status", 1, 12'h100, 32'h1);
    wr(1, 12'h110, 32'hFFFF_FFFF);
    chk("R7 tx lo cleared", {30'd0, ctl_irq}, 32'd0);
    rchk("R4 sender sees done", 0, 12'h100, 32'h0);
    wr(0, 12'h128, 32'h0000_0003);
    chk("R7 tx hi irq", {30'd0, ctl_irq}, 32'd2);
  endtask

  task automatic t_collide;
    // tx hi holds 0x3; set 0xFF and clear 0xF0F in one cycle -> 0xFF
    @(negedge clk);
    app_req = 1; app_we = 1; app_addr = 12'h128; app_wdata = 32'h0000_00FF;
    ctl_req = 1; ctl_we = 1; ctl_addr = 12'h130; ctl_wdata = 32'h0000_0F0F;
    @(negedge clk);
    app_req = 0; app_we = 0; ctl_req = 0; ctl_we = 0;
    rchk("R5 set wins", 1, 12'h120, 32'h0000_00FF);
    // both sides set different bits of rx lo together
    @(negedge clk);
    app_req = 1; app_we = 1; app_addr = 12'h008; app_wdata = 32'h0000_0100;
    ctl_req = 1; ctl_we = 1; ctl_addr = 12'h008; ctl_wdata = 32'h0000_0002;
    @(negedge clk);
    app_req = 0; app_we = 0; ctl_req = 0; ctl_we = 0;
    rchk("R5 dual set", 0, 12'h000, 32'h0000_0102);
    wr(1, 12'h130, 32'hFFFF_FFFF);
    wr(0, 12'h010, 32'hFFFF_FFFF);
    chk("R7 all clear", {30'd0, ctl_irq}, 32'd0);
  endtask

  task automatic t_decode;
    wr(1, 12'h008, 32'h0000_00A5);
    rchk("R8 set reads zero", 0, 12'h008, 32'h0);
    rchk("R8 clear reads zero", 0, 12'h010, 32'h0);
    rchk("R8 reserved reads zero", 0, 12'h018, 32'h0);
    rchk("R8 unmapped reads zero", 1, 12'h040, 32'h0);
    wr(0, 12'h048, 32'h0000_FFFF);
    wr(0, 12'h00C, 32'h0000_FF00);
    wr(1, 12'h050, 32'hFFFF_FFFF);
    rchk("R8 rx lo unchanged", 0, 12'h000, 32'h0000_00A5);
    rchk("R8 rx hi unchanged", 0, 12'h020, 32'h0);
    chk("R8 no stray irq", {30'd0, app_irq}, 32'd1);
    wr(0, 12'h010, 32'hFFFF_FFFF);
  endtask

  task automatic t_payload;
    wr(1, 12'h804, 32'h1111_1111);
    wr(1, 12'hC00, 32'h2222_2222);
    wr(0, 12'hA00, 32'h3333_3333);
    wr(0, 12'hFFC, 32'h4444_4444);
    rchk("R10 rx lo word1", 0, 12'h804, 32'h1111_1111);
    rchk("R10 rx hi word0", 0, 12'hC00, 32'h2222_2222);
    rchk("R10 tx lo word0", 1, 12'hA00, 32'h3333_3333);
    rchk("R10 tx hi last", 1, 12'hFFC, 32'h4444_4444);
    rchk("R10 writer readback", 1, 12'h804, 32'h1111_1111);
    wr(0, 12'h804, 32'hDEAD_BEEF);
    rchk("R11 app cannot write rx", 0, 12'h804, 32'h1111_1111);
    wr(1, 12'hA00, 32'hBEEF_CAFE);
    rchk("R11 ctl cannot write tx", 1, 12'hA00, 32'h3333_3333);
    rchk("R8 payload write no status", 0, 12'h000, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rx_low();
    t_rx_high();
    t_tx();
    t_collide();
    t_decode();
    t_payload();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule